// File: doc/BRIEF.md
# Bidirectional Port Select and Mailbox Decoder

This block is the control and data-steering slice for one side of a bidirectional FIFO port. Four control inputs are sampled on the rising port clock: an active-low chip select, a direction select (low = write, high = read), an enable and a mailbox select. Together they decide whether an edge performs a FIFO write, a mailbox write, a FIFO read or a mailbox read, or does nothing. The FIFO storage and its flags live elsewhere and are reached through one-cycle push and pop strobes that the storage samples on the same edge.

The port data bus is modelled as a data-out vector plus a separate output enable. Output enable follows chip select and direction combinationally, with no clocked term. While the bus is driven, it carries either the FIFO output register or the incoming mailbox register, picked by the mailbox select. The block holds two mailbox registers, each with an active-low full flag. The outgoing register is loaded from this port and drained by the far side. The incoming register is loaded by the far side and drained by this port.

Top module: `bidir_port_ctrl`

## Requirements
- R1: While cs_ni is 1, data_oe_o is 0, neither fifo_push_o nor fifo_pop_o is asserted, and no clock edge changes either mailbox, whatever the other port controls are.
- R2: With cs_ni = 0 and wr_rd_i = 0 (write direction), data_oe_o is 0.
- R3: With cs_ni = 0, wr_rd_i = 0, en_i = 1 and mbx_sel_i = 0, fifo_push_o is 1 in that cycle and fifo_wdata_o equals data_i.
- R4: A rising edge with cs_ni = 0, wr_rd_i = 0, en_i = 1 and mbx_sel_i = 1, while out_full_no is 1, loads data_i into the outgoing mailbox. From the next cycle, far_mbx_data_o shows that word and out_full_no is 0.
- R5: A mailbox write from the port while out_full_no is 0 is ignored: far_mbx_data_o keeps its value.
- R6: With cs_ni = 0 and wr_rd_i = 1, data_oe_o is 1 in the same cycle. data_o equals fifo_rdata_i when mbx_sel_i = 0, and the incoming mailbox word when mbx_sel_i = 1.
- R7: With cs_ni = 0, wr_rd_i = 1, en_i = 1 and mbx_sel_i = 0, fifo_pop_o is 1 in that cycle.
- R8: A rising edge with cs_ni = 0, wr_rd_i = 1, en_i = 1 and mbx_sel_i = 1 sets in_full_no to 1 from the next cycle.
- R9: With en_i = 0, no push, pop or mailbox change occurs, even if cs_ni and wr_rd_i change during the cycle. The bus enable still follows R2 and R6.
- R10: After reset, out_full_no and in_full_no are 1 and both mailbox words are zero.
- R11: far_mbx_rd_i at a rising edge sets out_full_no to 1. far_mbx_wr_i at a rising edge loads far_mbx_wdata_i into the incoming mailbox and clears in_full_no, but only while in_full_no is 1; otherwise the write is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Port clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Chip select, active low |
| wr_rd_i | input | 1 | Direction: 0 write, 1 read |
| en_i | input | 1 | Operation enable, sampled at the rising edge |
| mbx_sel_i | input | 1 | 0 selects FIFO, 1 selects mailbox |
| data_i | input | DATA_W | Bus data driven into the block |
| data_o | output | DATA_W | Bus data driven out |
| data_oe_o | output | 1 | Bus output enable |
| fifo_push_o | output | 1 | FIFO write strobe |
| fifo_wdata_o | output | DATA_W | FIFO write data |
| fifo_pop_o | output | 1 | FIFO read strobe |
| fifo_rdata_i | input | DATA_W | FIFO output register value |
| far_mbx_rd_i | input | 1 | Far side drains the outgoing mailbox |
| far_mbx_data_o | output | DATA_W | Outgoing mailbox word |
| out_full_no | output | 1 | Outgoing mailbox full, active low |
| far_mbx_wr_i | input | 1 | Far side loads the incoming mailbox |
| far_mbx_wdata_i | input | DATA_W | Word for the incoming mailbox |
| in_full_no | output | 1 | Incoming mailbox full, active low |

## Verification
The bus enable, the bus data, the push and pop strobes and the FIFO write data are combinational. They are due in the same cycle as the controls that produce them. The bench drives inputs on the falling edge and compares these outputs one nanosecond later. The mailbox words and full flags change on the rising edge that samples an operation. The reference model updates its own state at that edge, and the next falling-edge comparison sees the new values one cycle after the stimulus.

// File: rtl/bpc_pkg.sv
package bpc_pkg;
  typedef enum logic [2:0] {
    OP_NONE    = 3'd0,
    OP_FIFO_WR = 3'd1,
    OP_MBX_WR  = 3'd2,
    OP_FIFO_RD = 3'd3,
    OP_MBX_RD  = 3'd4
  } port_op_e;

  localparam int unsigned MBX_OUT = 0;
  localparam int unsigned MBX_IN  = 1;
  localparam int unsigned MBX_NUM = 2;
endpackage

// File: rtl/bpc_decode.sv
module bpc_decode
  import bpc_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     cs_ni,
  input  logic     wr_rd_i,
  input  logic     en_i,
  input  logic     mbx_sel_i,
  output port_op_e op_o,
  output logic     oe_o
);
  always_comb begin
    op_o = OP_NONE;
    if (!cs_ni && en_i) begin
      unique case ({wr_rd_i, mbx_sel_i})
        2'b00:   op_o = OP_FIFO_WR;
        2'b01:   op_o = OP_MBX_WR;
        2'b10:   op_o = OP_FIFO_RD;
        default: op_o = OP_MBX_RD;
      endcase
    end
  end

  // tri-state control: no clocked term
  assign oe_o = !cs_ni && wr_rd_i;

  // R1
  cs_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_ni |-> (op_o == OP_NONE && !oe_o));
  // R9
  en_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> op_o == OP_NONE);
endmodule

// File: rtl/bpc_mbx_reg.sv
module bpc_mbx_reg #(
  parameter int unsigned DATA_W = 36
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              rd_i,
  output logic [DATA_W-1:0] data_o,
  output logic              full_no
);
  logic              full_q;
  logic [DATA_W-1:0] data_q;
  logic              load;

  // a write into a full mailbox is dropped
  assign load = wr_i && !full_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else begin
      if (load) data_q <= wdata_i;
      if (full_q && rd_i) full_q <= 1'b0;
      else if (load)      full_q <= 1'b1;
    end
  end

  assign data_o  = data_q;
  assign full_no = !full_q;

  // R4
  load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_no && wr_i) |=> (!full_no && data_o == $past(wdata_i)));
  // R5
  full_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!full_no && !rd_i) |=> ($stable(data_o) && !full_no));
  // R8
  release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!full_no && rd_i) |=> full_no);
endmodule

// File: rtl/bpc_bus_mux.sv
module bpc_bus_mux #(
  parameter int unsigned DATA_W = 36
) (
  input  logic              oe_i,
  input  logic              mbx_sel_i,
  input  logic [DATA_W-1:0] fifo_q_i,
  input  logic [DATA_W-1:0] mbx_q_i,
  output logic [DATA_W-1:0] bus_o
);
  always_comb begin
    bus_o = '0;
    if (oe_i) bus_o = mbx_sel_i ? mbx_q_i : fifo_q_i;
  end
endmodule

// File: rtl/bidir_port_ctrl.sv
module bidir_port_ctrl
  import bpc_pkg::*;
#(
  parameter int unsigned DATA_W = 36
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              wr_rd_i,
  input  logic              en_i,
  input  logic              mbx_sel_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] data_o,
  output logic              data_oe_o,
  output logic              fifo_push_o,
  output logic [DATA_W-1:0] fifo_wdata_o,
  output logic              fifo_pop_o,
  input  logic [DATA_W-1:0] fifo_rdata_i,
  input  logic              far_mbx_rd_i,
  output logic [DATA_W-1:0] far_mbx_data_o,
  output logic              out_full_no,
  input  logic              far_mbx_wr_i,
  input  logic [DATA_W-1:0] far_mbx_wdata_i,
  output logic              in_full_no
);
  port_op_e          op;
  logic              oe;
  logic [MBX_NUM-1:0] mb_wr, mb_rd, mb_full_n;
  logic [DATA_W-1:0]  mb_wdata [MBX_NUM];
  logic [DATA_W-1:0]  mb_data  [MBX_NUM];

  bpc_decode u_decode (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cs_ni    (cs_ni),
    .wr_rd_i  (wr_rd_i),
    .en_i     (en_i),
    .mbx_sel_i(mbx_sel_i),
    .op_o     (op),
    .oe_o     (oe)
  );

  assign fifo_push_o  = (op == OP_FIFO_WR);
  assign fifo_pop_o   = (op == OP_FIFO_RD);
  assign fifo_wdata_o = data_i;

  // slot MBX_OUT: port writes, far side reads; slot MBX_IN: the reverse
  assign mb_wr[MBX_OUT]    = (op == OP_MBX_WR);
  assign mb_rd[MBX_OUT]    = far_mbx_rd_i;
  assign mb_wdata[MBX_OUT] = data_i;
  assign mb_wr[MBX_IN]     = far_mbx_wr_i;
  assign mb_rd[MBX_IN]     = (op == OP_MBX_RD);
  assign mb_wdata[MBX_IN]  = far_mbx_wdata_i;

  for (genvar g = 0; g < MBX_NUM; g++) begin : g_mbx
    bpc_mbx_reg #(.DATA_W(DATA_W)) u_mbx (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .wr_i   (mb_wr[g]),
      .wdata_i(mb_wdata[g]),
      .rd_i   (mb_rd[g]),
      .data_o (mb_data[g]),
      .full_no(mb_full_n[g])
    );
  end

  assign far_mbx_data_o = mb_data[MBX_OUT];
  assign out_full_no    = mb_full_n[MBX_OUT];
  assign in_full_no     = mb_full_n[MBX_IN];

  bpc_bus_mux #(.DATA_W(DATA_W)) u_mux (
    .oe_i     (oe),
    .mbx_sel_i(mbx_sel_i),
    .fifo_q_i (fifo_rdata_i),
    .mbx_q_i  (mb_data[MBX_IN]),
    .bus_o    (data_o)
  );
  assign data_oe_o = oe;

  // R3 R7
  op_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({fifo_push_o, fifo_pop_o, mb_wr[MBX_OUT], mb_rd[MBX_IN]}));
  // R6
  bus_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_oe_o |-> (data_o == (mbx_sel_i ? mb_data[MBX_IN] : fifo_rdata_i)));
  // R2
  wr_dir_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_rd_i) |-> !data_oe_o);
endmodule

// File: tb/bidir_port_ctrl_bench.sv
module bidir_port_ctrl_bench;
  localparam int W = 36;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b1, wr_rd = 1'b0, en = 1'b0, mbx = 1'b0;
  logic far_rd = 1'b0, far_wr = 1'b0;
  logic [W-1:0] din = '0, frd = '0, fwd = '0;
  logic [W-1:0] dout, fwdata, far_q;
  logic oe, push, pop, ofull_n, ifull_n;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  // reference state
  bit m_ofull = 0, m_ifull = 0;
  logic [W-1:0] m_odata = '0, m_idata = '0;
  string otag = "R10", itag = "R10";

  always #2 clk = ~clk;

  bidir_port_ctrl #(.DATA_W(W)) u_bidir_port_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .wr_rd_i(wr_rd), .en_i(en),
    .mbx_sel_i(mbx), .data_i(din), .data_o(dout), .data_oe_o(oe),
    .fifo_push_o(push), .fifo_wdata_o(fwdata), .fifo_pop_o(pop),
    .fifo_rdata_i(frd), .far_mbx_rd_i(far_rd), .far_mbx_data_o(far_q),
    .out_full_no(ofull_n), .far_mbx_wr_i(far_wr), .far_mbx_wdata_i(fwd),
    .in_full_no(ifull_n)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ofull = 0; m_ifull = 0; m_odata = '0; m_idata = '0;
      otag = "R10"; itag = "R10";
    end else begin
      bit act, pw, pr;
      act = !cs_n && en;
      pw = act && !wr_rd && mbx;
      pr = act && wr_rd && mbx;
      otag = cs_n ? "R1" : (!en ? "R9" : "R4");
      if (m_ofull) begin
        if (far_rd) begin m_ofull = 0; otag = "R11"; end
        else if (pw) otag = "R5";
      end else if (pw) begin
        m_ofull = 1; m_odata = din;
      end
      itag = "R11";
      if (m_ifull) begin
        if (pr) begin m_ifull = 0; itag = "R8"; end
      end else if (far_wr) begin
        m_ifull = 1; m_idata = fwd;
      end
    end
  end

  task automatic chk(string req, string what, logic [W-1:0] act, logic [W-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h t=%0t", req, what, act, exp, $time);
    end
  endtask

  task automatic compare();
    string stag;
    bit e_oe;
    e_oe = !cs_n && wr_rd;
    stag = cs_n ? "R1" : (!en ? "R9" : "R3");
    chk(cs_n ? "R1" : (wr_rd ? "R6" : "R2"), "oe", W'(oe), W'(e_oe));
    if (e_oe) chk("R6", "data_o", dout, mbx ? m_idata : frd);
    chk(stag, "push", W'(push), W'(!cs_n && en && !wr_rd && !mbx));
    chk(stag == "R3" ? "R7" : stag, "pop", W'(pop), W'(!cs_n && en && wr_rd && !mbx));
    if (push) chk("R3", "fifo_wdata", fwdata, din);
    chk(otag, "out_full_n", W'(ofull_n), W'(!m_ofull));
    chk(otag, "far_data", far_q, m_odata);
    chk(itag, "in_full_n", W'(ifull_n), W'(!m_ifull));
  endtask

  task automatic step(bit c, bit d, bit e, bit m, bit fr, bit fw);
    @(negedge clk);
    cs_n = c; wr_rd = d; en = e; mbx = m; far_rd = fr; far_wr = fw;
    din = {$urandom, $urandom}; frd = {$urandom, $urandom}; fwd = {$urandom, $urandom};
    #1 compare();
  endtask

  initial begin
    repeat (2) @(negedge clk);
    #1;
    chk("R10", "out_full_n rst", W'(ofull_n), W'(1));
    chk("R10", "in_full_n rst", W'(ifull_n), W'(1));
    chk("R10", "far_data rst", far_q, '0);
    @(negedge clk); rst_n = 1'b1;
    step(0, 0, 1, 0, 0, 0);   // R3 FIFO write
    step(0, 0, 1, 1, 0, 0);   // R4 mailbox write
    step(0, 0, 1, 1, 0, 0);   // R5 write into full mailbox
    step(0, 0, 0, 0, 0, 0);   // R5 observe held word
    step(1, 0, 1, 1, 1, 0);   // R1 with far read (R11)
    step(1, 1, 1, 1, 0, 1);   // R1 far write into incoming
    step(0, 1, 0, 1, 0, 1);   // R9 drive without consume; R11 ignored far write
    step(0, 1, 1, 0, 0, 0);   // R7 FIFO read
    step(0, 1, 1, 1, 0, 0);   // R8 mailbox read
    step(0, 1, 0, 0, 0, 0);
    for (int i = 0; i < 4000; i++)
      step($urandom_range(0, 3) == 0, $urandom_range(0, 1), $urandom_range(0, 2) != 0,
           $urandom_range(0, 1), $urandom_range(0, 3) == 0, $urandom_range(0, 2) == 0);
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule